// File: doc/BRIEF.md
# Split-Byte Sixteen-Bit Index Register

This block holds one 16-bit index register for a CPU core whose older instructions assume 8-bit indexes. The older operations (load, increment, decrement) act on the low byte alone. The low byte wraps within itself, and the high byte never changes through them. Code written for the 8-bit machine therefore keeps its behaviour. A second group of wide operations treats the register as one 16-bit value. These are increment, decrement, an unsigned compare against a 16-bit operand, and a swap of the two bytes.

The decoder presents one operation code and an enable. Every update lands on the rising clock edge. The low byte is always visible on an 8-bit store path, and the full value is visible for address generation. Each operation drives N, Z and C flag outputs, computed combinationally from the current value and operand, with a valid strobe that says which flags apply.

Top module: `idx_split_reg`

## Requirements
- R1: A synchronous active-low reset clears the register to 0x0000, and the flag-valid outputs are low while reset is held.
- R2: Operation code 1 (narrow load) writes `ld_lo` into bits 7:0 and leaves bits 15:8 unchanged.
- R3: Operation code 2 (narrow increment) adds one to bits 7:0 modulo 256, and bits 15:8 keep their value. For example, 0x00FF becomes 0x0000.
- R4: Operation code 3 (narrow decrement) subtracts one from bits 7:0 modulo 256, and bits 15:8 keep their value. For example, 0x0100 becomes 0x01FF.
- R5: Operation codes 4 and 5 (wide increment and wide decrement) add or subtract one on all 16 bits, with carry and borrow across bit 8. Both wrap modulo 65536.
- R6: Operation code 6 (wide compare) leaves the register unchanged. It gives C=1 when the register is at least `cmp_opnd` (unsigned), Z=1 on equality, and N equal to bit 15 of register minus operand.
- R7: Operation code 7 (byte swap) exchanges bits 15:8 and 7:0 in one clock.
- R8: For codes 1 to 3, N is bit 7 and Z reports bits 7:0 equal to zero, both of the result. For codes 4, 5 and 7, N is bit 15 and Z reports all 16 bits of the result zero. `nz_vld` is high for codes 1 to 7, and `c_vld` is high only for code 6.
- R9: With `en` low, or with operation code 0, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Update enable |
| op | input | 3 | Operation code (0 none, 1 to 7 as in the requirements) |
| ld_lo | input | 8 | Narrow load data |
| cmp_opnd | input | 16 | Wide compare operand |
| idx_q | output | 16 | Full register value |
| st_lo | output | 8 | Low byte for narrow store |
| flag_n | output | 1 | Negative flag of the current operation |
| flag_z | output | 1 | Zero flag of the current operation |
| flag_c | output | 1 | Carry flag (wide compare only) |
| nz_vld | output | 1 | N and Z are meaningful |
| c_vld | output | 1 | C is meaningful |

## Verification
The assertions check on every cycle that the narrow operations keep the high byte, that a compare leaves the value in place, that the swap exchanges the bytes, and that an idle or disabled cycle holds the register. Only the bench scenarios can show the exact arithmetic at the byte boundary: the 0x00FF and 0x0100 wraps, the wide carry and borrow, and the flag values for a compare under equal, smaller and larger operands.

// File: rtl/idx_split_pkg.sv
// Package idx_split_pkg
// Holds the operation codes and the flag bundle shared by the index register
// datapath and its state holder. Assumes a 3-bit operation field.
package idx_split_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LD8   = 3'd1,
        OP_INC8  = 3'd2,
        OP_DEC8  = 3'd3,
        OP_INC16 = 3'd4,
        OP_DEC16 = 3'd5,
        OP_CMP16 = 3'd6,
        OP_SWAP  = 3'd7
    } idx_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic nz_vld;
        logic c_vld;
    } idx_flags_t;
endpackage

// File: rtl/idx_split_alu.sv
// Module idx_split_alu
// Combinational next-value and flag logic for one split-byte index register.
// Narrow operations touch only the low HALF bits. Wide ones use all W bits.
// Assumes W is even. Produces a write strobe; the caller owns the storage.
module idx_split_alu
    import idx_split_pkg::*;
#(
    parameter int W = 16
) (
    input  idx_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W/2-1:0] ld_lo,
    input  logic [W-1:0]   cmp_opnd,
    output logic [W-1:0]   nxt,
    output logic           wr,
    output idx_flags_t     flags
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] lo_inc, lo_dec;
    logic [W:0]      diff;

    // narrow arithmetic confined to the low half
    always_comb begin
        lo_inc = cur[HALF-1:0] + 1'b1;
        lo_dec = cur[HALF-1:0] - 1'b1;
    end

    // wide subtract with an extra bit that carries the borrow
    always_comb diff = {1'b0, cur} - {1'b0, cmp_opnd};

    // select the next value and the write strobe
    always_comb begin
        nxt = cur;
        wr  = 1'b1;
        unique case (op)
            OP_LD8:   nxt = {cur[W-1:HALF], ld_lo};
            OP_INC8:  nxt = {cur[W-1:HALF], lo_inc};
            OP_DEC8:  nxt = {cur[W-1:HALF], lo_dec};
            OP_INC16: nxt = cur + 1'b1;
            OP_DEC16: nxt = cur - 1'b1;
            OP_SWAP:  nxt = {cur[HALF-1:0], cur[W-1:HALF]};
            default:  wr  = 1'b0;
        endcase
    end

    // flags: narrow ops look at the low half, wide ops at the full result
    always_comb begin
        flags = '0;
        unique case (op)
            OP_LD8, OP_INC8, OP_DEC8: begin
                flags.n      = nxt[HALF-1];
                flags.z      = (nxt[HALF-1:0] == '0);
                flags.nz_vld = 1'b1;
            end
            OP_INC16, OP_DEC16, OP_SWAP: begin
                flags.n      = nxt[W-1];
                flags.z      = (nxt == '0);
                flags.nz_vld = 1'b1;
            end
            OP_CMP16: begin
                flags.n      = diff[W-1];
                flags.z      = (diff[W-1:0] == '0);
                flags.c      = ~diff[W];
                flags.nz_vld = 1'b1;
                flags.c_vld  = 1'b1;
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/idx_split_store.sv
// Module idx_split_store
// The register itself: loads nxt when enabled and the datapath asks for a write.
// Synchronous active-low reset to zero. Carries the per-cycle assertions.
module idx_split_store
    import idx_split_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wr,
    input  idx_op_e      op,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    localparam int HALF = W / 2;

    // state update on the rising edge
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (en && wr) q <= nxt;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> q == '0);
    p_narrow_keeps_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en && (op == OP_LD8 || op == OP_INC8 || op == OP_DEC8)
        |=> q[W-1:HALF] == $past(q[W-1:HALF]));
    p_cmp_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en && op == OP_CMP16 |=> $stable(q));
    p_swap_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en && op == OP_SWAP
        |=> q == {$past(q[HALF-1:0]), $past(q[W-1:HALF])});
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || op == OP_NONE) |=> $stable(q));
endmodule

// File: rtl/idx_split_reg.sv
// Module idx_split_reg (top)
// One 16-bit index register with narrow legacy ops and wide extended ops.
// Assumes decode and operand fetch happen outside; op is already decoded.
// Flags are combinational from the current value and the operand.
module idx_split_reg
    import idx_split_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [2:0]     op,
    input  logic [W/2-1:0] ld_lo,
    input  logic [W-1:0]   cmp_opnd,
    output logic [W-1:0]   idx_q,
    output logic [W/2-1:0] st_lo,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_c,
    output logic           nz_vld,
    output logic           c_vld
);
    localparam int HALF = W / 2;

    idx_op_e    op_e;
    logic [W-1:0] nxt;
    logic       wr;
    idx_flags_t fl;

    // cast the raw code to the package enum
    always_comb op_e = idx_op_e'(op);

    idx_split_alu #(.W(W)) i_alu (
        .op(op_e), .cur(idx_q), .ld_lo(ld_lo), .cmp_opnd(cmp_opnd),
        .nxt(nxt), .wr(wr), .flags(fl)
    );

    idx_split_store #(.W(W)) i_store (
        .clk(clk), .rst_n(rst_n), .en(en), .wr(wr), .op(op_e),
        .nxt(nxt), .q(idx_q)
    );

    // outputs; flags are gated by enable and reset
    always_comb begin
        st_lo  = idx_q[HALF-1:0];
        flag_n = fl.n;
        flag_z = fl.z;
        flag_c = fl.c;
        nz_vld = fl.nz_vld & en & rst_n;
        c_vld  = fl.c_vld & en & rst_n;
    end

    p_cvld_only_cmp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        c_vld |-> op == 3'd6 && nz_vld);
endmodule

// File: tb/test_idx_split_reg.sv
module test_idx_split_reg;
    logic        clk = 1'b0;
    logic        rst_n, en;
    logic [2:0]  op;
    logic [7:0]  ld_lo;
    logic [15:0] cmp_opnd;
    logic [15:0] idx_q;
    logic [7:0]  st_lo;
    logic        flag_n, flag_z, flag_c, nz_vld, c_vld;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    idx_split_reg i_idx_split_reg (.*);

    // vector: op, ld, cmp, expected q after, expected N, Z, C (flags before edge)
    typedef struct packed {
        logic [2:0]  op; logic [7:0] ld; logic [15:0] cmp;
        logic [15:0] q; logic n; logic z; logic c;
    } vec_t;
    localparam vec_t VECS [14] = '{
        '{3'd1, 8'hFF, 16'h0, 16'h00FF, 1'b1, 1'b0, 1'b0},   // R2 load
        '{3'd2, 8'h00, 16'h0, 16'h0000, 1'b0, 1'b1, 1'b0},   // R3 wrap FF->00
        '{3'd3, 8'h00, 16'h0, 16'h00FF, 1'b1, 1'b0, 1'b0},   // R4 wrap 00->FF
        '{3'd4, 8'h00, 16'h0, 16'h0100, 1'b0, 1'b0, 1'b0},   // R5 carry
        '{3'd3, 8'h00, 16'h0, 16'h01FF, 1'b1, 1'b0, 1'b0},   // R4 0100->01FF
        '{3'd2, 8'h00, 16'h0, 16'h0100, 1'b0, 1'b1, 1'b0},   // R3 high kept, Z low
        '{3'd5, 8'h00, 16'h0, 16'h00FF, 1'b0, 1'b0, 1'b0},   // R5 borrow
        '{3'd7, 8'h00, 16'h0, 16'hFF00, 1'b1, 1'b0, 1'b0},   // R7 swap
        '{3'd6, 8'h00, 16'hFF00, 16'hFF00, 1'b0, 1'b1, 1'b1},// R6 equal
        '{3'd6, 8'h00, 16'hFF01, 16'hFF00, 1'b1, 1'b0, 1'b0},// R6 less
        '{3'd6, 8'h00, 16'h0001, 16'hFF00, 1'b1, 1'b0, 1'b1},// R6 greater
        '{3'd1, 8'h34, 16'h0, 16'hFF34, 1'b0, 1'b0, 1'b0},   // R2 high kept
        '{3'd0, 8'h00, 16'h0, 16'hFF34, 1'b0, 1'b0, 1'b0},   // R9 idle
        '{3'd5, 8'h00, 16'h0, 16'hFF33, 1'b1, 1'b0, 1'b0}    // R8 wide N
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #4000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; op = 3'd4; ld_lo = 0; cmp_opnd = 0;
        @(posedge clk); @(posedge clk); #5;
        chk("R1 reset value", idx_q, 16'h0);
        chk("R1 vld low in reset", {nz_vld, c_vld}, 2'b00);
        rst_n = 1'b1;
        foreach (VECS[i]) begin
            @(negedge clk);
            op = VECS[i].op; ld_lo = VECS[i].ld; cmp_opnd = VECS[i].cmp;
            #2;
            if (VECS[i].op != 3'd0) begin
                chk("R8 flag N", flag_n, VECS[i].n);
                chk("R8 flag Z", flag_z, VECS[i].z);
                chk("R8 nz_vld", nz_vld, 1'b1);
                chk("R8 c_vld", c_vld, VECS[i].op == 3'd6);
                if (VECS[i].op == 3'd6) chk("R6 flag C", flag_c, VECS[i].c);
            end else chk("R9 vld idle", nz_vld, 1'b0);
            @(posedge clk); #5;
            chk($sformatf("vector %0d value (R2-R9 group)", i), idx_q, VECS[i].q);
        end
        // R9: enable low blocks update
        @(negedge clk); en = 1'b0; op = 3'd4;
        @(posedge clk); #5;
        chk("R9 disabled hold", idx_q, 16'hFF33);
        chk("R9 st_lo path", st_lo, 8'h33);
        // R5: wide wrap 0000 -> FFFF, then FFFF -> 0000
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #5;
        chk("R1 reset mid-run", idx_q, 16'h0);
        @(negedge clk); rst_n = 1'b1; en = 1'b1; op = 3'd5;
        @(posedge clk); #5;
        chk("R5 wide wrap down", idx_q, 16'hFFFF);
        @(negedge clk); op = 3'd4; #2;
        chk("R8 wide Z on wrap", flag_z, 1'b1);
        @(posedge clk); #5;
        chk("R5 wide wrap up", idx_q, 16'h0000);
        @(negedge clk); en = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule